// File: doc/BRIEF.md
# CAN Controller Interrupt Unit

This block turns the status levels and event strobes of a CAN controller into a 9-bit interrupt status word and one active-high interrupt request line. The status levels are: receive queue non-empty, transmit buffer free, data overrun, error warning, bus-off and error passive. The event strobes are: arbitration lost, bus error and bus idle. The host supplies a 9-bit enable word and a one-cycle strobe that marks a read of the status word.

The sources trigger in different ways. The receive bit is a plain level and follows queue occupancy. The transmit and overrun bits latch on a rising edge of their status. The warning and error-passive bits latch on any change of their status. The three strobe bits latch on the strobe itself. A latched bit stays set until the host reads the status word. Edges are found by comparing each level with a registered copy of it. The first cycle after reset only loads those copies, so a level that is already high when reset is released does not count as an edge.

Top module: `can_irq_unit`

## Requirements
- R1: Status bit 0 is high in exactly the cycles in which `rxq_nonempty` and `irq_en[0]` are both high. It is combinational and does not latch.
- R2: Bit 1 is set at the clock edge that samples a 0-to-1 change of `txbuf_free` while `irq_en[1]` is high. A 1-to-0 change does not set it.
- R3: Bit 2 is set at the clock edge that samples any change, in either direction, of `warn_st` or of `busoff_st` while `irq_en[2]` is high.
- R4: Bit 3 is set at the clock edge that samples a 0-to-1 change of `overrun_st` while `irq_en[3]` is high.
- R5: Bit 4 always reads 0.
- R6: Bit 5 is set at the clock edge that samples any change of `passive_st` while `irq_en[5]` is high. This covers entering error passive and returning to error active.
- R7: Bits 6, 7 and 8 are set at the clock edge that samples `arb_lost_pulse`, `bus_err_pulse` or `idle_pulse` respectively high while the matching enable bit is high.
- R8: An event seen while its enable bit is low sets nothing. A bit that is already set stays set when its enable bit is later cleared.
- R9: A clock edge that samples `stat_rd` high clears bits 1-3 and 5-8, unless an enabled event for that bit is sampled at the same edge, in which case the bit stays set. Bit 0 is not affected by `stat_rd`.
- R10: `irq_req` is the OR of all bits of `irq_stat`.
- R11: While reset is active, and after it is released, all latched bits are 0. The first clock edge after reset only loads the registered copies of the levels, so a level that is already high at that edge is not taken as a rising edge or a change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rxq_nonempty | input | 1 | Receive queue holds at least one message |
| txbuf_free | input | 1 | Transmit buffer is free for the host |
| overrun_st | input | 1 | Data overrun status |
| warn_st | input | 1 | An error counter is at or above the warning limit |
| busoff_st | input | 1 | Node is bus-off |
| passive_st | input | 1 | Node is error passive |
| arb_lost_pulse | input | 1 | One-cycle strobe: arbitration lost |
| bus_err_pulse | input | 1 | One-cycle strobe: bus error detected |
| idle_pulse | input | 1 | One-cycle strobe: controller became idle |
| irq_en | input | 9 | Per-bit interrupt enable, bit positions as in `irq_stat` |
| stat_rd | input | 1 | Host read of the status word; clears latched bits |
| irq_stat | output | 9 | Interrupt status word |
| irq_req | output | 1 | Interrupt request, active high |

## Verification
The bench drives a long stream of random levels, strobes, enables and reads. A cycle model built from the requirements predicts the status word, and each bit is compared against it in every cycle. Directed sequences target the corners:
- A level that is already high when reset is released. A design without the first-cycle load would raise a false transmit interrupt.
- A falling change on the warning, bus-off and error-passive inputs. A design that detects only rising edges would miss the return to error active.
- An event in the same cycle as a status read. A design where the clear takes priority would lose that interrupt.
- An enable bit cleared while its bit is set. A design that gates the output instead of the set would drop a pending interrupt.

// File: rtl/can_irq_pkg.sv
// Shared constants of the CAN interrupt unit: status bit positions and the
// order of the edge-detected level inputs.
package can_irq_pkg;
    localparam int IRQ_W     = 9;   // width of the status word
    localparam int B_RX      = 0;
    localparam int B_TX      = 1;
    localparam int B_WARN    = 2;
    localparam int B_OVR     = 3;
    localparam int B_RSVD    = 4;
    localparam int B_PASSIVE = 5;
    localparam int B_ARB     = 6;
    localparam int B_BUSERR  = 7;
    localparam int B_IDLE    = 8;

    // Edge-detected levels, in this order inside the level vector
    localparam int L_TX      = 0;
    localparam int L_OVR     = 1;
    localparam int L_WARN    = 2;
    localparam int L_BUSOFF  = 3;
    localparam int L_PASSIVE = 4;
    localparam int LVL_W     = 5;
    // 1 = any change triggers, 0 = rising edge only
    localparam logic [LVL_W-1:0] LVL_ANY_CHANGE = 5'b11100;

    // Latched status bits (all but bit 0 and reserved bit 4)
    localparam int STICKY_W  = 7;
endpackage

// File: rtl/can_irq_edge.sv
// Edge detector for a vector of status levels.
// Each level is compared with a registered copy of itself. Per bit, the
// parameter ANY_CHANGE selects "any change" (1) or "rising edge only" (0).
// Assumes: the levels are synchronous to clk. The first cycle after reset
// only loads the copies and reports no edge.
module can_irq_edge #(
    parameter int W = 5,
    parameter logic [W-1:0] ANY_CHANGE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] det_o
);
    logic [W-1:0] prev_q;
    logic         armed_q;

    // Hold the previous levels; mark once the copies are valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= lvl_i;
            armed_q <= 1'b1;
        end
    end

    // Per-bit detect variant chosen by parameter
    for (genvar i = 0; i < W; i++) begin : g_det
        if (ANY_CHANGE[i]) begin : g_chg
            assign det_o[i] = armed_q & (lvl_i[i] ^ prev_q[i]);
        end else begin : g_rise
            assign det_o[i] = armed_q & lvl_i[i] & ~prev_q[i];
        end
    end
endmodule

// File: rtl/can_irq_sticky.sv
// Bank of set-priority sticky bits.
// A bit is set by set_i and cleared by clr_i. When both are high in one
// cycle, set wins.
// Assumes: clr_i is a single-cycle read strobe.
module can_irq_sticky #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        // One sticky flag: set dominates clear
        always_ff @(posedge clk) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_i[i])   bit_q <= 1'b1;
            else if (clr_i)      bit_q <= 1'b0;
        end
        assign q_o[i] = bit_q;
    end
endmodule

// File: rtl/can_irq_unit.sv
// CAN controller interrupt unit (top).
// Builds the 9-bit interrupt status word from status levels and event
// strobes, and drives the request line. Bit 0 follows the receive queue
// level. Bits 1-3 and 5-8 latch until a host read. Bit 4 is reserved and
// reads 0.
// Assumes: all inputs are synchronous to clk; strobes last one cycle.
module can_irq_unit
    import can_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxq_nonempty,
    input  logic             txbuf_free,
    input  logic             overrun_st,
    input  logic             warn_st,
    input  logic             busoff_st,
    input  logic             passive_st,
    input  logic             arb_lost_pulse,
    input  logic             bus_err_pulse,
    input  logic             idle_pulse,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             stat_rd,
    output logic [IRQ_W-1:0] irq_stat,
    output logic             irq_req
);
    logic [LVL_W-1:0]    lvl;
    logic [LVL_W-1:0]    det;
    logic [STICKY_W-1:0] set_vec;
    logic [STICKY_W-1:0] sticky;

    // Pack the edge-detected levels in package order
    always_comb begin
        lvl            = '0;
        lvl[L_TX]      = txbuf_free;
        lvl[L_OVR]     = overrun_st;
        lvl[L_WARN]    = warn_st;
        lvl[L_BUSOFF]  = busoff_st;
        lvl[L_PASSIVE] = passive_st;
    end

    can_irq_edge #(
        .W          (LVL_W),
        .ANY_CHANGE (LVL_ANY_CHANGE)
    ) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (lvl),
        .det_o (det)
    );

    // Enabled set requests; sticky index k maps to status bit (k<3 ? k+1 : k+2)
    always_comb begin
        set_vec[0] = det[L_TX]                      & irq_en[B_TX];
        set_vec[1] = (det[L_WARN] | det[L_BUSOFF])  & irq_en[B_WARN];
        set_vec[2] = det[L_OVR]                     & irq_en[B_OVR];
        set_vec[3] = det[L_PASSIVE]                 & irq_en[B_PASSIVE];
        set_vec[4] = arb_lost_pulse                 & irq_en[B_ARB];
        set_vec[5] = bus_err_pulse                  & irq_en[B_BUSERR];
        set_vec[6] = idle_pulse                     & irq_en[B_IDLE];
    end

    can_irq_sticky #(
        .W (STICKY_W)
    ) sticky_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (stat_rd),
        .q_o   (sticky)
    );

    // Assemble the status word and the request line
    always_comb begin
        irq_stat            = '0;
        irq_stat[B_RX]      = rxq_nonempty & irq_en[B_RX];
        irq_stat[B_TX]      = sticky[0];
        irq_stat[B_WARN]    = sticky[1];
        irq_stat[B_OVR]     = sticky[2];
        irq_stat[B_RSVD]    = 1'b0;
        irq_stat[B_PASSIVE] = sticky[3];
        irq_stat[B_ARB]     = sticky[4];
        irq_stat[B_BUSERR]  = sticky[5];
        irq_stat[B_IDLE]    = sticky[6];
        irq_req             = |irq_stat;
    end
endmodule

// File: rtl/can_irq_unit_chk.sv
// Checker for can_irq_unit. It keeps its own "armed" flag so that an edge
// is only judged once a previous sample exists.
module can_irq_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txbuf_free,
    input logic       warn_st,
    input logic       busoff_st,
    input logic       passive_st,
    input logic       arb_lost_pulse,
    input logic       idle_pulse,
    input logic [8:0] irq_en,
    input logic       stat_rd,
    input logic [8:0] irq_stat
);
    logic armed_q;

    // Valid previous sample exists from the second cycle after reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_TX_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && irq_en[1] && $rose(txbuf_free) |=> irq_stat[1]); // R2

    AST_WARN_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && irq_en[2] && (!$stable(warn_st) || !$stable(busoff_st)) |=> irq_stat[2]); // R3

    AST_PASSIVE_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && irq_en[5] && !$stable(passive_st) |=> irq_stat[5]); // R6

    AST_ARB_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_stat[6] && !(arb_lost_pulse && irq_en[6]) |=> !irq_stat[6]); // R8

    AST_IDLE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !idle_pulse |=> !irq_stat[8]); // R9

    AST_IDLE_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && idle_pulse && irq_en[8] |=> irq_stat[8]); // R9
endmodule

bind can_irq_unit can_irq_unit_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .txbuf_free     (txbuf_free),
    .warn_st        (warn_st),
    .busoff_st      (busoff_st),
    .passive_st     (passive_st),
    .arb_lost_pulse (arb_lost_pulse),
    .idle_pulse     (idle_pulse),
    .irq_en         (irq_en),
    .stat_rd        (stat_rd),
    .irq_stat       (irq_stat)
);

// File: tb/can_irq_unit_tb.sv
// Bench for can_irq_unit. A cycle model built from the requirements
// predicts the status word. Directed sequences come first, then a long
// random sweep over levels, strobes, enables and reads.
module can_irq_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SWEEP_N    = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxq_nonempty = 0, txbuf_free = 0, overrun_st = 0, warn_st = 0;
    logic       busoff_st = 0, passive_st = 0;
    logic       arb_lost_pulse = 0, bus_err_pulse = 0, idle_pulse = 0;
    logic [8:0] irq_en = '0;
    logic       stat_rd = 0;
    logic [8:0] irq_stat;
    logic       irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench model state
    logic [8:0] m_stat = '0;   // latched bits (bit 0 and bit 4 unused)
    logic [4:0] m_prev = '0;   // tx, ovr, warn, busoff, passive
    bit         m_armed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .rxq_nonempty(rxq_nonempty),
        .txbuf_free(txbuf_free), .overrun_st(overrun_st), .warn_st(warn_st),
        .busoff_st(busoff_st), .passive_st(passive_st),
        .arb_lost_pulse(arb_lost_pulse), .bus_err_pulse(bus_err_pulse),
        .idle_pulse(idle_pulse), .irq_en(irq_en), .stat_rd(stat_rd),
        .irq_stat(irq_stat), .irq_req(irq_req)
    );

    function automatic string bit_tag(int b);
        case (b)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic compare(string tag);
        logic [8:0] exp;
        exp    = m_stat;
        exp[0] = rxq_nonempty & irq_en[0];
        exp[4] = 1'b0;
        for (int b = 0; b < 9; b++) begin
            checks++;
            if (irq_stat[b] !== exp[b]) begin
                failures++;
                $display("FAIL %s bit%0d actual=%b expected=%b", (tag == "") ? bit_tag(b) : tag,
                         b, irq_stat[b], exp[b]);
            end
        end
        checks++;
        if (irq_req !== (|exp)) begin
            failures++;
            $display("FAIL R10 irq_req actual=%b expected=%b", irq_req, |exp);
        end
    endtask

    // One clock: model the edge, then compare after the edge
    task automatic step(string tag);
        logic [4:0] cur;
        logic [8:0] ev;
        logic [8:0] nxt;
        cur = {passive_st, busoff_st, warn_st, overrun_st, txbuf_free};
        ev  = '0;
        if (m_armed) begin
            ev[1] = cur[0] & ~m_prev[0];
            ev[2] = (cur[2] ^ m_prev[2]) | (cur[3] ^ m_prev[3]);
            ev[3] = cur[1] & ~m_prev[1];
            ev[5] = cur[4] ^ m_prev[4];
        end
        ev[6] = arb_lost_pulse;
        ev[7] = bus_err_pulse;
        ev[8] = idle_pulse;
        nxt = (stat_rd ? 9'b0 : m_stat) | (ev & irq_en);
        @(posedge clk);
        m_prev  = cur;
        m_armed = 1;
        m_stat  = nxt;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic clear_strobes();
        arb_lost_pulse = 0; bus_err_pulse = 0; idle_pulse = 0; stat_rd = 0;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset with levels already high
        txbuf_free = 1; overrun_st = 1; passive_st = 1; irq_en = 9'h1EE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R11");
        rst_n = 1;
        m_stat = '0; m_armed = 0;
        repeat (3) step("R11");

        // R2 / R4: fall then rise
        txbuf_free = 0; overrun_st = 0; step("R2");
        compare("R4");
        stat_rd = 1; step("R9"); stat_rd = 0;
        txbuf_free = 1; step("R2");
        overrun_st = 1; step("R4");
        // R3 / R6: changes in both directions
        stat_rd = 1; step("R9"); stat_rd = 0;
        warn_st = 1; step("R3");
        stat_rd = 1; step("R9"); stat_rd = 0;
        warn_st = 0; step("R3");
        stat_rd = 1; step("R9"); stat_rd = 0;
        busoff_st = 1; step("R3");
        passive_st = 0; step("R6");
        stat_rd = 1; step("R9"); stat_rd = 0;
        passive_st = 1; step("R6");
        // R7: each strobe
        stat_rd = 1; step("R9"); stat_rd = 0;
        arb_lost_pulse = 1; step("R7"); clear_strobes();
        bus_err_pulse = 1; step("R7"); clear_strobes();
        idle_pulse = 1; step("R7"); clear_strobes();
        // R9: same-cycle event wins, bit 0 untouched
        rxq_nonempty = 1; irq_en[0] = 1; step("R1");
        stat_rd = 1; bus_err_pulse = 1; step("R9"); clear_strobes();
        stat_rd = 1; step("R9"); clear_strobes();
        // R8: disabled events ignored; pending bit survives enable clear
        irq_en = '0;
        arb_lost_pulse = 1; bus_err_pulse = 1; idle_pulse = 1;
        txbuf_free = 0; warn_st = 1; passive_st = 0; step("R8"); clear_strobes();
        txbuf_free = 1; step("R8");
        irq_en[6] = 1; arb_lost_pulse = 1; step("R8"); clear_strobes();
        irq_en = '0; step("R8"); step("R8");
        stat_rd = 1; step("R8"); clear_strobes();
        // R5 / R1 and all: random sweep
        for (int n = 0; n < SWEEP_N; n++) begin
            logic [31:0] r;
            r = $urandom;
            rxq_nonempty   = r[0];
            txbuf_free     = r[1] ^ txbuf_free & r[2];
            overrun_st     = r[3] & r[4];
            warn_st        = r[5] & r[6];
            busoff_st      = r[7] & r[8] & r[9];
            passive_st     = r[10] & r[11];
            arb_lost_pulse = r[12] & r[13];
            bus_err_pulse  = r[14] & r[15];
            idle_pulse     = r[16] & r[17];
            stat_rd        = r[18] & r[19];
            irq_en         = (n < SWEEP_N/2) ? 9'h1FF : r[28:20];
            step("");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule